// File: doc/BRIEF.md
# Physical Address Remap and Chip-Select Unit

This block takes a 20-bit physical address and turns it into the address and strobes that reach external memory. The address is remapped in two stages. The first stage may flip address bit 16 and/or bit 19, but only on a data-space access in the root zone or in the data zone. It does this so that code and data at the same logical place can sit in different devices. The top two bits of the result pick one of four quadrants.

Each quadrant has its own bank control word. That word may flip bit 18 and/or bit 19 of the outgoing address. Because this flip happens after the quadrant is chosen, it never moves the access to a different bank word. The bank word also picks which of three chip selects to drive, and whether a read drives output enable and a write drives write enable.

A write port with a 3-bit index and 8 bits of data loads the separation control word and the four bank words. The address path and all strobes are combinational from the inputs and the stored words. Segment translation and bus timing are handled elsewhere; the access zone and the access type arrive as inputs.

Top module: `phys_remap_cs`

## Requirements
- R1: Reset clears every control word. The outgoing address then equals the incoming address, an access (rd or wr high) drives cs_n[0] low, and oe_n and we_n stay high.
- R2: When is_data is 0 (instruction space), the separation stage never changes the address.
- R3: When zone is 2 or 3 (zone encoding: 0 root, 1 data, 2/3 other), the separation stage never changes the address.
- R4: On a data access in zone 0, separation word bit 0 flips address bit 16 and bit 1 flips address bit 19.
- R5: On a data access in zone 1, separation word bit 2 flips address bit 16 and bit 3 flips address bit 19.
- R6: The quadrant is bits 19:18 of the address after the separation stage. Quadrant q is governed by bank word q, which is loaded at write index q+1.
- R7: Bank word bit 4 flips outgoing bit 18 and bit 5 flips outgoing bit 19. This flip does not change the quadrant. Bits 17:0 pass through the bank stage unchanged.
- R8: Bank word bits 1:0 with a value of 0, 1 or 2 drive that cs_n line low, but only while rd or wr is high. A value of 3 drives none. With no forcing, at most one cs_n is low.
- R9: oe_n is low exactly when rd is high and bank bit 2 is set. we_n is low exactly when wr is high and bank bit 3 is set.
- R10: Separation word bit 4 holds cs_n[1] low at all times, idle or not. The decoded chip select of the current bank is still driven as well.
- R11: Write index 0 loads the separation word and indices 1 to 4 load bank words 0 to 3. Indices 5 to 7 are ignored. Bits 7:5 of the separation word and bits 7:6 of a bank word are discarded. A written value governs accesses from the cycle after the write edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the control words |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_idx | input | 3 | Control word index |
| cfg_wdata | input | 8 | Control word write data |
| addr_in | input | 20 | Physical address before remap |
| is_data | input | 1 | 1 for a data-space access |
| zone | input | 2 | Access zone: 0 root, 1 data, 2/3 other |
| rd | input | 1 | Read access |
| wr | input | 1 | Write access |
| addr_out | output | 20 | Address driven to memory |
| cs_n | output | 3 | Active-low chip selects |
| oe_n | output | 1 | Active-low output enable |
| we_n | output | 1 | Active-low write enable |

## Verification
A control word write and a live access that depends on that word can fall in the same cycle. The bench holds an access steady while a new separation word is presented on the write port. It samples the outputs before the write edge and expects the old mapping. It samples again after the edge and expects the new quadrant, the new bank word and the new strobes. The forced chip select is also provoked together with a decoded chip select in one access, and both lines are expected low.

// File: rtl/remap_pkg.sv
// Package: shared types and constants for the physical remap unit.
// Assumes a four-quadrant map selected by the top two address bits.
package remap_pkg;
    localparam int QSEL_W    = 2;
    localparam int NUM_BANKS = 1 << QSEL_W;
    localparam int FORCED_CS = 1;

    typedef enum logic [1:0] {
        ZONE_ROOT  = 2'd0,
        ZONE_DATA  = 2'd1,
        ZONE_OTHR  = 2'd2,
        ZONE_OTHR2 = 2'd3
    } zone_e;

    // Bank word, bit 5 down to bit 0.
    typedef struct packed {
        logic       flip_top;   // flip address MSB after quadrant pick
        logic       flip_quad;  // flip address MSB-1 after quadrant pick
        logic       we_en;
        logic       oe_en;
        logic [1:0] cs_pick;
    } bank_cfg_t;

    // Separation word, bit 4 down to bit 0.
    typedef struct packed {
        logic hold_cs1;
        logic dz_flip_top;
        logic dz_flip_page;
        logic rz_flip_top;
        logic rz_flip_page;
    } sep_cfg_t;
endpackage

// File: rtl/remap_cfg_regs.sv
// Module: control word storage for the separation word and the bank words.
// Assumes index 0 = separation word, 1..NUM_BANKS = banks; others ignored.
module remap_cfg_regs
    import remap_pkg::*;
#(
    parameter int IDX_W = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cfg_we,
    input  logic [IDX_W-1:0]            cfg_idx,
    input  logic [7:0]                  cfg_wdata,
    output sep_cfg_t                    sep_q,
    output bank_cfg_t [NUM_BANKS-1:0]   bank_q
);
    localparam int SEP_W  = $bits(sep_cfg_t);
    localparam int BANK_W = $bits(bank_cfg_t);

    logic unused_rsvd_bits;
    assign unused_rsvd_bits = ^cfg_wdata[7:SEP_W];

    // Load the separation word on index 0.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sep_q <= '0;
        else if (cfg_we && cfg_idx == '0)
            sep_q <= sep_cfg_t'(cfg_wdata[SEP_W-1:0]);
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        // Load bank word b on index b+1.
        always_ff @(posedge clk) begin
            if (!rst_n)
                bank_q[b] <= '0;
            else if (cfg_we && cfg_idx == IDX_W'(b + 1))
                bank_q[b] <= bank_cfg_t'(cfg_wdata[BANK_W-1:0]);
        end
    end

    // R11: an out-of-range index leaves every word untouched.
    assert_bad_index_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_idx > IDX_W'(NUM_BANKS)) |=> ($stable(sep_q) && $stable(bank_q)));
endmodule

// File: rtl/remap_sep_stage.sv
// Module: instruction/data separation flips, applied before quadrant pick.
// Assumes only data accesses in the root or data zone are eligible.
module remap_sep_stage
    import remap_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              is_data,
    input  logic [1:0]        zone,
    input  sep_cfg_t          sep_cfg,
    output logic [ADDR_W-1:0] addr_mid
);
    localparam int TOP_BIT  = ADDR_W - 1;
    localparam int PAGE_BIT = ADDR_W - 4;
    localparam logic [ADDR_W-1:0] FLIP_SPAN = (ADDR_W'(1) << TOP_BIT) | (ADDR_W'(1) << PAGE_BIT);

    logic in_root, in_dseg, flip_top, flip_page;

    // Build the flip mask from zone, access kind and separation word.
    always_comb begin
        in_root   = is_data && (zone == ZONE_ROOT);
        in_dseg   = is_data && (zone == ZONE_DATA);
        flip_top  = (in_root && sep_cfg.rz_flip_top)  || (in_dseg && sep_cfg.dz_flip_top);
        flip_page = (in_root && sep_cfg.rz_flip_page) || (in_dseg && sep_cfg.dz_flip_page);
        addr_mid  = addr_in;
        addr_mid[TOP_BIT]  = addr_in[TOP_BIT]  ^ flip_top;
        addr_mid[PAGE_BIT] = addr_in[PAGE_BIT] ^ flip_page;
    end

    assert_instr_untouched_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !is_data |-> (addr_mid == addr_in));
    assert_other_zone_untouched_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (zone != ZONE_ROOT && zone != ZONE_DATA) |-> (addr_mid == addr_in));
    // R4 / R5: only the two eligible bits can ever differ.
    assert_only_two_bits_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((addr_mid ^ addr_in) & ~FLIP_SPAN) == '0);
endmodule

// File: rtl/remap_bank_stage.sv
// Module: quadrant pick, post-pick bank flips and strobe decode.
// Assumes the bank words arrive already registered; output is combinational.
module remap_bank_stage
    import remap_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int NUM_CS = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [ADDR_W-1:0]         addr_mid,
    input  logic                      rd,
    input  logic                      wr,
    input  bank_cfg_t [NUM_BANKS-1:0] bank_cfg,
    input  logic                      hold_cs1,
    output logic [ADDR_W-1:0]         addr_out,
    output logic [NUM_CS-1:0]         cs_n,
    output logic                      oe_n,
    output logic                      we_n
);
    localparam int QHI = ADDR_W - 1;
    localparam int QLO = ADDR_W - QSEL_W;

    logic [QSEL_W-1:0] quad;
    bank_cfg_t         sel;
    logic              active;

    // Pick the bank word and apply its post-pick flips.
    always_comb begin
        quad     = addr_mid[QHI:QLO];
        sel      = bank_cfg[quad];
        active   = rd || wr;
        addr_out = addr_mid;
        addr_out[QHI]   = addr_mid[QHI]   ^ sel.flip_top;
        addr_out[QHI-1] = addr_mid[QHI-1] ^ sel.flip_quad;
        oe_n     = !(rd && sel.oe_en);
        we_n     = !(wr && sel.we_en);
    end

    for (genvar c = 0; c < NUM_CS; c++) begin : g_cs
        if (c == FORCED_CS) begin : g_forced
            // Decoded select, or held low by the separation word.
            assign cs_n[c] = !((active && sel.cs_pick == 2'(c)) || hold_cs1);
        end else begin : g_plain
            // Decoded select only.
            assign cs_n[c] = !(active && sel.cs_pick == 2'(c));
        end
    end

    assert_low_bits_pass_R7: assert property (@(posedge clk) disable iff (!rst_n)
        addr_out[QLO-1:0] == addr_mid[QLO-1:0]);
    assert_cs_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !hold_cs1 |-> $onehot0(~cs_n));
    assert_idle_no_cs_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd && !wr && !hold_cs1) |-> (&cs_n));
    assert_oe_needs_rd_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_n |-> rd);
    assert_we_needs_wr_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |-> wr);
    assert_hold_cs1_R10: assert property (@(posedge clk) disable iff (!rst_n)
        hold_cs1 |-> !cs_n[FORCED_CS]);
endmodule

// File: rtl/phys_remap_cs.sv
// Module: top of the physical remap and chip-select unit.
// Assumes zone and access kind come from the segment translator upstream.
module phys_remap_cs
    import remap_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int NUM_CS = 3,
    parameter int IDX_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [7:0]        cfg_wdata,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              is_data,
    input  logic [1:0]        zone,
    input  logic              rd,
    input  logic              wr,
    output logic [ADDR_W-1:0] addr_out,
    output logic [NUM_CS-1:0] cs_n,
    output logic              oe_n,
    output logic              we_n
);
    sep_cfg_t                  sep_q;
    bank_cfg_t [NUM_BANKS-1:0] bank_q;
    logic [ADDR_W-1:0]         addr_mid;

    remap_cfg_regs #(.IDX_W(IDX_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_wdata(cfg_wdata), .sep_q(sep_q), .bank_q(bank_q)
    );

    remap_sep_stage #(.ADDR_W(ADDR_W)) u_sep (
        .clk(clk), .rst_n(rst_n), .addr_in(addr_in), .is_data(is_data),
        .zone(zone), .sep_cfg(sep_q), .addr_mid(addr_mid)
    );

    remap_bank_stage #(.ADDR_W(ADDR_W), .NUM_CS(NUM_CS)) u_bank (
        .clk(clk), .rst_n(rst_n), .addr_mid(addr_mid), .rd(rd), .wr(wr),
        .bank_cfg(bank_q), .hold_cs1(sep_q.hold_cs1), .addr_out(addr_out),
        .cs_n(cs_n), .oe_n(oe_n), .we_n(we_n)
    );
endmodule

// File: tb/tb_phys_remap_cs.sv
module tb_phys_remap_cs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_idx = '0;
    logic [7:0]  cfg_wdata = '0;
    logic [19:0] addr_in = '0;
    logic        is_data = 1'b0;
    logic [1:0]  zone = '0;
    logic        rd = 1'b0;
    logic        wr = 1'b0;
    logic [19:0] addr_out;
    logic [2:0]  cs_n;
    logic        oe_n, we_n;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;  // 250 MHz

    phys_remap_cs dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_wdata(cfg_wdata), .addr_in(addr_in), .is_data(is_data),
        .zone(zone), .rd(rd), .wr(wr), .addr_out(addr_out), .cs_n(cs_n),
        .oe_n(oe_n), .we_n(we_n)
    );

    // Vector: sep[4:0], addr[19:0], is_data, zone[1:0], rd, wr,
    //         then expected addr[19:0], cs_n[2:0], oe_n, we_n.
    // Banks: b0=0x0C (cs0,oe,we) b1=0x05 (cs1,oe) b2=0x1E (cs2,oe,we,flip18)
    //        b3=0x2B (no cs,we,flip19)
    localparam int NV = 10;
    localparam logic [54:0] VECS [NV] = '{
        {5'h00, 20'h01234, 1'b1, 2'd1, 1'b1, 1'b0, 20'h01234, 3'b110, 1'b0, 1'b1}, // R6 R9 plain
        {5'h08, 20'h01234, 1'b1, 2'd1, 1'b1, 1'b0, 20'hC1234, 3'b011, 1'b0, 1'b1}, // R5 R6 R7
        {5'h08, 20'h01234, 1'b0, 2'd1, 1'b1, 1'b0, 20'h01234, 3'b110, 1'b0, 1'b1}, // R2
        {5'h08, 20'h01234, 1'b1, 2'd2, 1'b1, 1'b0, 20'h01234, 3'b110, 1'b0, 1'b1}, // R3
        {5'h01, 20'h40000, 1'b1, 2'd0, 1'b0, 1'b1, 20'h50000, 3'b101, 1'b1, 1'b1}, // R4 R9
        {5'h02, 20'h40000, 1'b1, 2'd0, 1'b0, 1'b1, 20'h40000, 3'b111, 1'b1, 1'b0}, // R4 R7 R8
        {5'h04, 20'h8FFFF, 1'b1, 2'd1, 1'b1, 1'b1, 20'hDFFFF, 3'b011, 1'b0, 1'b0}, // R5 R7
        {5'h00, 20'h30000, 1'b1, 2'd1, 1'b0, 1'b0, 20'h30000, 3'b111, 1'b1, 1'b1}, // R8 idle
        {5'h10, 20'h30000, 1'b1, 2'd1, 1'b0, 1'b0, 20'h30000, 3'b101, 1'b1, 1'b1}, // R10 idle
        {5'h10, 20'h80000, 1'b1, 2'd1, 1'b1, 1'b0, 20'hC0000, 3'b001, 1'b0, 1'b1}  // R10 + decoded
    };
    localparam string VTAG [NV] = '{"R6", "R5", "R2", "R3", "R4", "R7", "R5", "R8", "R10", "R10"};

    task automatic chk(input string req, input logic [24:0] exp);
        logic [24:0] act;
        act = {addr_out, cs_n, oe_n, we_n};
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: {addr,cs_n,oe_n,we_n} actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [2:0] idx, input logic [7:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = idx; cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic access(input logic [19:0] a, input logic d, input logic [1:0] z,
                          input logic r, input logic w);
        addr_in = a; is_data = d; zone = z; rd = r; wr = w;
    endtask

    initial begin
        #(4 * 150000);
        failures++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: cleared words give passthrough and cs0 only.
        access(20'hC1234, 1'b1, 2'd1, 1'b1, 1'b0); #1;
        chk("R1 reset state", {20'hC1234, 3'b110, 1'b1, 1'b1});

        // R11: reserved bits discarded.
        wr_reg(3'd1, 8'hC0);
        wr_reg(3'd0, 8'hE0);
        access(20'h01234, 1'b1, 2'd0, 1'b1, 1'b0); #1;
        chk("R11 reserved bits", {20'h01234, 3'b110, 1'b1, 1'b1});

        // R11: out-of-range indices ignored.
        wr_reg(3'd5, 8'hFF);
        wr_reg(3'd6, 8'hFF);
        wr_reg(3'd7, 8'hFF);
        #1;
        chk("R11 bad index", {20'h01234, 3'b110, 1'b1, 1'b1});

        // Bank setup, then the table.
        wr_reg(3'd1, 8'h0C);
        wr_reg(3'd2, 8'h05);
        wr_reg(3'd3, 8'h1E);
        wr_reg(3'd4, 8'h2B);
        for (int i = 0; i < NV; i++) begin
            wr_reg(3'd0, {3'b000, VECS[i][54:50]});
            access(VECS[i][49:30], VECS[i][29], VECS[i][28:27], VECS[i][26], VECS[i][25]);
            #1;
            chk(VTAG[i], VECS[i][24:0]);
        end

        // R11: write and dependent access in the same cycle.
        @(negedge clk);
        access(20'h01234, 1'b1, 2'd1, 1'b1, 1'b0);
        cfg_we = 1'b1; cfg_idx = 3'd0; cfg_wdata = 8'h08;
        #1;
        chk("R11 before write edge", {20'h01234, 3'b100, 1'b0, 1'b1});
        @(negedge clk);
        cfg_we = 1'b0;
        #1;
        chk("R11 after write edge", {20'hC1234, 3'b011, 1'b0, 1'b1});

        // R1: reset mid-run clears every word.
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        access(20'h01234, 1'b1, 2'd1, 1'b1, 1'b0); #1;
        chk("R1 reset mid-run", {20'h01234, 3'b110, 1'b1, 1'b1});

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule